// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. It samples the line once per pulse of an enable running at sixteen times the bit rate. The enable can come from a shared baud generator or from a separate receive clock domain that has already been brought onto the block clock. A falling edge is only accepted as a start bit if the line is still low half a bit later; otherwise the edge is treated as noise and the receiver goes back to looking for a new edge. Once a start bit is confirmed, each data bit, the optional parity bit and the first stop bit are sampled at the centre of their bit periods.

Each finished character is stored together with three flags: parity error, framing error and break. Storage is either a first-in first-out queue or a single holding register, chosen at run time. A line that stays low through a whole character time is reported once as a break, and nothing more is received until the line goes high again. A loopback select replaces the external line with the local transmitter's serial output. The host side reads the oldest stored entry and removes it with a one-cycle pop.

Top module: `oversamp_serial_rx`

## Requirements
- R1: The character length is set by `char_len`: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. Bits are received least significant first, and any unused upper bits of `rd_data` read 0.
- R2: With `par_en`=1, one parity bit follows the data. `par_even`=1 selects even parity and 0 selects odd. `rd_perr` is 1 when the received parity does not match the data. With `par_en`=0 no parity bit is expected and `rd_perr` is 0.
- R3: A character whose first stop bit is sampled low, and which is not a break, is stored with `rd_ferr`=1. Only the first stop bit is checked.
- R4: A falling edge that is high again at the middle of the start bit stores nothing and produces no `rx_ready`. The receiver then accepts the next valid frame normally.
- R5: The line may stay low from the start bit to the end of the full character time: half a bit after the first stop centre, plus one more stop bit when `stop_sel`=1, or half a bit when `stop_sel`=1 with 5-bit characters. In that case exactly one entry is stored, with data 0, `rd_brk`=1 and `rd_ferr`=0. No further character is received until the line has returned high.
- R6: Every bit of a character, stop bit included, may be sampled 0 but the line return high before the end of that character time. Such a character is stored as data 0 with `rd_ferr`=1 and `rd_brk`=0.
- R7: With `fifo_en`=1, up to DEPTH (16) entries are held and read back in arrival order. `data_ready` is 1 exactly while at least one entry is held, and a `pop` while `data_ready`=1 removes the oldest entry.
- R8: With `fifo_en`=0, storage holds a single entry.
- R9: A character may complete while storage is full. Then `overrun` pulses for one cycle, the new character is discarded and the held entries are unchanged. A push is judged against the occupancy before any same-cycle pop.
- R10: `rx_ready` pulses for one cycle for each entry written into storage, and never in the same cycle as `overrun`.
- R11: With `loop_en`=1 the receiver takes its input from `loop_src` and ignores `rx_line`.
- R12: After reset, `data_ready`, `overrun` and `rx_ready` are 0, and the receiver is hunting for a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Sampling enable at 16x the bit rate |
| rx_line | input | 1 | External serial input, idle high |
| loop_src | input | 1 | Local transmitter serial output, used in loopback |
| loop_en | input | 1 | Select loopback input |
| char_len | input | 2 | Data bits per character (00=5 ... 11=8) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| stop_sel | input | 1 | 0 = one stop bit, 1 = two (1.5 for 5-bit) |
| fifo_en | input | 1 | 1 = queue storage, 0 = single holding register |
| pop | input | 1 | Remove the oldest stored entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity error flag of the oldest entry |
| rd_ferr | output | 1 | Framing error flag of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| data_ready | output | 1 | At least one entry is stored |
| overrun | output | 1 | One-cycle pulse: a character was dropped because storage was full |
| rx_ready | output | 1 | One-cycle pulse: an entry was stored |

## Verification
The bench sweeps every character length, parity mode and stop setting with inverted data pairs, plus frames that carry a corrupted parity bit or a low stop bit. A design that sampled off-centre, counted the wrong number of bits or inverted the parity sense would show wrong data or flags there. Two all-zero cases sit on either side of the break rule: a long low line must give one break entry, while a zero frame whose line recovers inside the stop window must give a framing error only. A receiver that judged a break at the stop-bit centre would report the second case as a break. A glitch shorter than half a bit must leave storage untouched. Filling the queue one past its depth, and the single register one past its size, shows whether overrun drops the new character or overwrites the old ones. The loopback case holds the external line low, so a mux that leaked that line through would report a break.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int MAX_BITS = 8;

   typedef struct packed {
      logic                brk;
      logic                ferr;
      logic                perr;
      logic [MAX_BITS-1:0] data;
   } rx_entry_t;

   typedef enum logic [2:0] {
      S_HUNT,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP,
      S_BRKCHK,
      S_BRKWAIT
   } rx_state_t;

endpackage

// File: rtl/srx_front.sv
module srx_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_line,
   input  logic loop_src,
   input  logic loop_en,
   output logic line_s
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("srx_front: SYNC_STAGES must be at least 2");
   end

   logic                   raw;
   logic [SYNC_STAGES-1:0] chain;

   assign raw = loop_en ? loop_src : rx_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], raw};
   end

   assign line_s = chain[SYNC_STAGES-1];

endmodule

// File: rtl/srx_engine.sv
module srx_engine
   import srx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      line,
   input  logic [1:0] char_len,
   input  logic      par_en,
   input  logic      par_even,
   input  logic      stop_sel,
   output logic      push,
   output rx_entry_t push_ent
);

   localparam int CNT_W = $clog2(OSR);
   localparam int HALF  = OSR / 2;
   localparam int BRK_W = $clog2(2 * OSR + 1);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_chk_osr
      $error("srx_engine: OSR must be even and at least 4");
   end
   if (MAX_BITS != 8) begin : g_chk_bits
      $error("srx_engine: character field must be 8 bits");
   end

   rx_state_t           state;
   logic [CNT_W-1:0]    cnt;
   logic [BRK_W-1:0]    bcnt;
   logic [2:0]          bidx;
   logic [MAX_BITS-1:0] dat;
   logic                pbit;
   logic                all_zero;

   logic [2:0]          last_idx;
   logic [BRK_W-1:0]    brk_need;
   logic                par_bad;
   logic                at_half;
   logic                at_full;

   assign last_idx = {1'b0, char_len} + 3'd4;
   assign at_half  = (cnt == CNT_W'(HALF - 1));
   assign at_full  = (cnt == CNT_W'(OSR - 1));
   assign par_bad  = par_en & (^dat ^ pbit ^ ~par_even);

   always_comb begin
      brk_need = BRK_W'(HALF);
      if (stop_sel) begin
         if (char_len == 2'd0) brk_need = brk_need + BRK_W'(HALF);
         else                  brk_need = brk_need + BRK_W'(OSR);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_HUNT;
         cnt      <= '0;
         bcnt     <= '0;
         bidx     <= '0;
         dat      <= '0;
         pbit     <= 1'b0;
         all_zero <= 1'b0;
         push     <= 1'b0;
         push_ent <= '0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            unique case (state)
               S_HUNT: begin
                  if (!line) begin
                     state <= S_START;
                     cnt   <= '0;
                  end
               end
               S_START: begin
                  if (at_half) begin
                     cnt <= '0;
                     if (!line) begin
                        state    <= S_DATA;
                        bidx     <= '0;
                        dat      <= '0;
                        pbit     <= 1'b0;
                        all_zero <= 1'b1;
                     end else begin
                        state <= S_HUNT;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_DATA: begin
                  if (at_full) begin
                     cnt       <= '0;
                     dat[bidx] <= line;
                     if (line) all_zero <= 1'b0;
                     if (bidx == last_idx) state <= par_en ? S_PAR : S_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_PAR: begin
                  if (at_full) begin
                     cnt   <= '0;
                     pbit  <= line;
                     if (line) all_zero <= 1'b0;
                     state <= S_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_STOP: begin
                  if (at_full) begin
                     cnt <= '0;
                     if (line) begin
                        push     <= 1'b1;
                        push_ent <= '{brk: 1'b0, ferr: 1'b0, perr: par_bad, data: dat};
                        state    <= S_HUNT;
                     end else if (all_zero) begin
                        bcnt  <= '0;
                        state <= S_BRKCHK;
                     end else begin
                        push     <= 1'b1;
                        push_ent <= '{brk: 1'b0, ferr: 1'b1, perr: par_bad, data: dat};
                        state    <= S_HUNT;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_BRKCHK: begin
                  if (line) begin
                     push     <= 1'b1;
                     push_ent <= '{brk: 1'b0, ferr: 1'b1, perr: par_bad, data: dat};
                     state    <= S_HUNT;
                  end else if (bcnt == brk_need - 1'b1) begin
                     push     <= 1'b1;
                     push_ent <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
                     state    <= S_BRKWAIT;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               S_BRKWAIT: begin
                  if (line) state <= S_HUNT;
               end
               default: state <= S_HUNT;
            endcase
         end
      end
   end

   // R5: a break entry carries no data and no framing flag
   assert_brk_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && push_ent.brk) |-> (push_ent.data == '0 && !push_ent.ferr && !push_ent.perr));

   // R5: after a break, no entry until the line has been seen high
   assert_brk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_BRKWAIT && !line) |=> !push);

   // R4: a start edge is never followed directly by a stored entry
   assert_start_no_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_START) |=> !push);

endmodule

// File: rtl/srx_store.sv
module srx_store
   import srx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fifo_en,
   input  logic      push,
   input  rx_entry_t push_ent,
   input  logic      pop,
   output rx_entry_t head,
   output logic      not_empty,
   output logic      rdy_pulse,
   output logic      ovr_pulse
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_chk_depth
      $error("srx_store: DEPTH must be at least 1");
   end

   logic [CNT_W-1:0] count;
   logic             full;
   logic             accept;
   logic             pop_ok;

   assign not_empty = (count != '0);
   assign full      = fifo_en ? (count == CNT_W'(DEPTH)) : not_empty;
   assign accept    = push && !full;
   assign pop_ok    = pop && not_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         rdy_pulse <= 1'b0;
         ovr_pulse <= 1'b0;
      end else begin
         rdy_pulse <= accept;
         ovr_pulse <= push && full;
         case ({accept, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   if (DEPTH == 1) begin : g_single
      rx_entry_t hold;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hold <= '0;
         else if (accept) hold <= push_ent;
      end
      assign head = hold;
   end else begin : g_queue
      localparam int PTR_W = $clog2(DEPTH);
      rx_entry_t        mem [DEPTH];
      logic [PTR_W-1:0] wp;
      logic [PTR_W-1:0] rp;

      always_ff @(posedge clk) begin
         if (accept) mem[wp] <= push_ent;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp <= '0;
            rp <= '0;
         end else begin
            if (accept) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
         end
      end

      assign head = mem[rp];
   end

   // R7: occupancy never exceeds the queue depth
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R7: a lone pop removes exactly one entry
   assert_pop_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && not_empty) |=> (count == $past(count) - 1'b1));

   // R9: a push into full storage is flagged and leaves occupancy alone
   assert_ovr_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (ovr_pulse && count == $past(count)));

   // R10: stored and dropped strobes are exclusive
   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rdy_pulse && ovr_pulse));

endmodule

// File: rtl/oversamp_serial_rx.sv
module oversamp_serial_rx
   import srx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick16,
   input  logic                rx_line,
   input  logic                loop_src,
   input  logic                loop_en,
   input  logic [1:0]          char_len,
   input  logic                par_en,
   input  logic                par_even,
   input  logic                stop_sel,
   input  logic                fifo_en,
   input  logic                pop,
   output logic [MAX_BITS-1:0] rd_data,
   output logic                rd_perr,
   output logic                rd_ferr,
   output logic                rd_brk,
   output logic                data_ready,
   output logic                overrun,
   output logic                rx_ready
);

   logic      line_s;
   logic      push;
   rx_entry_t push_ent;
   rx_entry_t head;

   srx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_line  (rx_line),
      .loop_src (loop_src),
      .loop_en  (loop_en),
      .line_s   (line_s)
   );

   srx_engine #(.OSR(OSR)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .line     (line_s),
      .char_len (char_len),
      .par_en   (par_en),
      .par_even (par_even),
      .stop_sel (stop_sel),
      .push     (push),
      .push_ent (push_ent)
   );

   srx_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_en   (fifo_en),
      .push      (push),
      .push_ent  (push_ent),
      .pop       (pop),
      .head      (head),
      .not_empty (data_ready),
      .rdy_pulse (rx_ready),
      .ovr_pulse (overrun)
   );

   assign rd_data = head.data;
   assign rd_perr = head.perr;
   assign rd_ferr = head.ferr;
   assign rd_brk  = head.brk;

endmodule

// File: tb/sim_oversamp_serial_rx.sv
module sim_oversamp_serial_rx;

   localparam int CLK_PER = 10;
   localparam int TDIV    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] dv = 2'd0;
   logic       ser = 1'b1;
   logic       tgt = 1'b0;
   logic       loop_en = 1'b0;
   logic [1:0] char_len = 2'd3;
   logic       par_en = 1'b0;
   logic       par_even = 1'b0;
   logic       stop_sel = 1'b0;
   logic       fifo_en = 1'b1;
   logic       pop = 1'b0;
   logic       rx_line_i;
   logic       loop_src_i;
   logic [7:0] rd_data;
   logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun, rx_ready;

   int total = 0;
   int bad = 0;
   int n_rdy = 0;
   int n_ovr = 0;
   bit done = 1'b0;

   assign rx_line_i  = tgt ? 1'b0 : ser;
   assign loop_src_i = tgt ? ser : 1'b1;

   always #(CLK_PER / 2) clk = ~clk;

   always @(posedge clk) begin
      dv     <= dv + 2'd1;
      tick16 <= (dv == 2'(TDIV - 1));
      if (rst_n && rx_ready) n_rdy <= n_rdy + 1;
      if (rst_n && overrun)  n_ovr <= n_ovr + 1;
   end

   oversamp_serial_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line_i),
      .loop_src(loop_src_i), .loop_en(loop_en), .char_len(char_len),
      .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel),
      .fifo_en(fifo_en), .pop(pop), .rd_data(rd_data), .rd_perr(rd_perr),
      .rd_ferr(rd_ferr), .rd_brk(rd_brk), .data_ready(data_ready),
      .overrun(overrun), .rx_ready(rx_ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * TDIV) @(negedge clk);
   endtask

   task automatic do_pop();
      @(negedge clk) pop = 1'b1;
      @(negedge clk) pop = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                             input bit pev, input bit st2, input bit badp, input bit bads);
      logic p;
      @(negedge clk) ser = 1'b0;
      wait_ticks(16);
      for (int i = 0; i < nb; i++) begin
         ser = d[i];
         wait_ticks(16);
      end
      if (pen) begin
         p = 1'b0;
         for (int i = 0; i < nb; i++) p = p ^ d[i];
         p = p ^ ~pev;
         if (badp) p = ~p;
         ser = p;
         wait_ticks(16);
      end
      ser = bads ? 1'b0 : 1'b1;
      wait_ticks(16);
      ser = 1'b1;
      if (st2) wait_ticks(nb == 5 ? 8 : 16);
      wait_ticks(16);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int r0;
      int o0;
      logic [7:0] d;
      logic [7:0] m;
      int nb;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12 data_ready", {31'd0, data_ready}, 32'd0);
      check("R12 rx_ready", {31'd0, rx_ready}, 32'd0);
      check("R12 overrun", {31'd0, overrun}, 32'd0);

      // R1 R2 R3 R10: sweep length, parity and stop settings
      for (int len = 0; len < 4; len++) begin
         for (int pm = 0; pm < 3; pm++) begin
            for (int st = 0; st < 2; st++) begin
               for (int k = 0; k < 3; k++) begin
                  bit badp;
                  bit bads;
                  nb       = len + 5;
                  char_len = 2'(len);
                  par_en   = (pm != 0);
                  par_even = (pm == 2);
                  stop_sel = st[0];
                  m = 8'((1 << nb) - 1);
                  d = 8'hA5 ^ 8'(len * 37 + pm * 11 + st * 5);
                  if (k == 1) d = ~d;
                  badp = (k == 2) && par_en;
                  bads = (k == 2) && !par_en;
                  if (bads && (d & m) == 8'd0) d = 8'h01;
                  r0 = n_rdy;
                  send_frame(d, nb, par_en, par_even, stop_sel, badp, bads);
                  check("R10 one strobe", n_rdy - r0, 1);
                  check("R7 data_ready", {31'd0, data_ready}, 32'd1);
                  check("R1 data", {24'd0, rd_data}, {24'd0, d & m});
                  check("R2 parity flag", {31'd0, rd_perr}, {31'd0, badp});
                  check("R3 framing flag", {31'd0, rd_ferr}, {31'd0, bads});
                  do_pop();
                  check("R7 empty after pop", {31'd0, data_ready}, 32'd0);
               end
            end
         end
      end

      // R5: long low line gives one break entry
      char_len = 2'd3; par_en = 1'b0; stop_sel = 1'b0;
      r0 = n_rdy;
      @(negedge clk) ser = 1'b0;
      wait_ticks(16 * 14);
      ser = 1'b1;
      wait_ticks(32);
      check("R5 single entry", n_rdy - r0, 1);
      check("R5 break flag", {31'd0, rd_brk}, 32'd1);
      check("R5 break data", {24'd0, rd_data}, 32'd0);
      check("R5 break no ferr", {31'd0, rd_ferr}, 32'd0);
      do_pop();
      wait_ticks(32);
      check("R5 nothing after break", {31'd0, data_ready}, 32'd0);

      // R6: zero frame with recovering line is a framing error only
      stop_sel = 1'b1;
      r0 = n_rdy;
      send_frame(8'h00, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      check("R6 one entry", n_rdy - r0, 1);
      check("R6 ferr", {31'd0, rd_ferr}, 32'd1);
      check("R6 no brk", {31'd0, rd_brk}, 32'd0);
      check("R6 data", {24'd0, rd_data}, 32'd0);
      do_pop();
      stop_sel = 1'b0;

      // R4: short glitch is rejected, next frame received
      r0 = n_rdy;
      @(negedge clk) ser = 1'b0;
      wait_ticks(4);
      ser = 1'b1;
      wait_ticks(48);
      check("R4 no strobe", n_rdy - r0, 0);
      check("R4 nothing stored", {31'd0, data_ready}, 32'd0);
      send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R4 next frame", {24'd0, rd_data}, 32'h3C);
      do_pop();

      // R7 R9: queue fills to depth, extra character dropped
      fifo_en = 1'b1;
      r0 = n_rdy; o0 = n_ovr;
      for (int i = 0; i < 17; i++) send_frame(8'(i * 7 + 1), 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R9 one overrun", n_ovr - o0, 1);
      check("R10 sixteen stored", n_rdy - r0, 16);
      for (int i = 0; i < 16; i++) begin
         check("R7 order", {24'd0, rd_data}, 32'(8'(i * 7 + 1)));
         do_pop();
      end
      check("R7 drained", {31'd0, data_ready}, 32'd0);

      // R8 R9: single holding register
      fifo_en = 1'b0;
      o0 = n_ovr;
      send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R8 overrun on second", n_ovr - o0, 1);
      check("R9 first kept", {24'd0, rd_data}, 32'h11);
      do_pop();
      check("R8 single entry", {31'd0, data_ready}, 32'd0);
      fifo_en = 1'b1;

      // R11: loopback ignores low external line
      @(negedge clk) begin tgt = 1'b1; loop_en = 1'b1; end
      par_en = 1'b1; par_even = 1'b1;
      r0 = n_rdy;
      send_frame(8'h96, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R11 one entry", n_rdy - r0, 1);
      check("R11 data", {24'd0, rd_data}, 32'h96);
      check("R11 no break", {31'd0, rd_brk}, 32'd0);
      check("R11 no perr", {31'd0, rd_perr}, 32'd0);
      do_pop();
      @(negedge clk) begin tgt = 1'b0; loop_en = 1'b0; end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule